// File: doc/BRIEF.md
# Measurement Limit Monitor with Maskable Interrupt

This block watches a stream of finished measurements and raises an interrupt when any of them leaves its programmed window. Every measurement arrives as a one-cycle strobe carrying a channel index and an unsigned code. Channel 0 is the temperature reading, channel 1 the supply-voltage reading, and channels 2 upward are the auxiliary analog inputs. Each channel owns an upper and a lower limit register. A result strictly outside the window sets a sticky flag in the status register. Reading the status register returns the flags and clears them.

A mask register selects which flags may reach the interrupt line. The line is modelled as an open-drain pad: `irq_oe` says when the pad pulls, and `irq_o` gives the level it pulls to. A configuration bit picks that level, and after reset the level is low. A simple register port with write strobe, read strobe and address reaches all limits, the status, the mask and the configuration. Read data appears one cycle after the read strobe.

Top module: `lim_monitor`

## Requirements
- R1: After reset every upper limit reads all ones, every lower limit reads zero, status, mask and configuration read zero, and `irq_oe` is low.
- R2: A strobed result strictly greater than its channel's upper limit sets status bit 2*ch in the cycle after the strobe. A result equal to the limit sets nothing.
- R3: A strobed result strictly less than its channel's lower limit sets status bit 2*ch+1 in the cycle after the strobe. A result equal to the limit sets nothing.
- R4: Only the channel named by `result_ch` is compared. An index of NUM_CH or more, or a cycle with `result_valid` low, changes no status bit.
- R5: A status bit stays set through later in-range results until the status register is read.
- R6: A read of the status address (2*NUM_CH) returns the flags one cycle later and clears them. A flag set by a result in the same cycle as the read is kept and is not part of that read's data.
- R7: Setting mask bit k (mask address 2*NUM_CH+1) keeps status bit k from driving the interrupt, while the status bit is still recorded.
- R8: `irq_oe` is high exactly when some status bit is set and its mask bit is clear. It rises in the same cycle the flag becomes visible, and it falls once a read has cleared the flags.
- R9: Configuration bit 0 (address 2*NUM_CH+2) sets the driven level `irq_o`: 0 gives active low, 1 gives active high.
- R10: The upper limit of channel ch sits at address 2*ch and the lower limit at 2*ch+1. Both read back as written and apply from the next result on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| result_valid | input | 1 | One-cycle strobe marking a new measurement |
| result_ch | input | 3 | Channel index of the measurement |
| result_val | input | 10 | Unsigned measurement code |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Register read data, valid the cycle after `reg_re` |
| irq_oe | output | 1 | Interrupt pad drive enable (line pulled when high) |
| irq_o | output | 1 | Level driven onto the interrupt line while enabled |

## Verification
A status flag becomes visible one clock edge after its strobe, and `irq_oe` follows in that same cycle because it is decoded from registered state. Read data is due one edge after the read strobe. The bench drives every stimulus on the falling edge and samples on the next falling edge, so each result is read exactly one edge after the cause. For each channel it sweeps every code against two limits, and it places a read and a strobe in the same cycle to check which of the two wins.

// File: rtl/lim_pkg.sv
package lim_pkg;

  typedef enum logic {
    POL_ACT_LOW  = 1'b0,
    POL_ACT_HIGH = 1'b1
  } irq_pol_e;

  // Register map: limits first (two per channel), then status, mask, config.
  function automatic int unsigned hi_addr(input int unsigned ch);
    return 2 * ch;
  endfunction

  function automatic int unsigned lo_addr(input int unsigned ch);
    return 2 * ch + 1;
  endfunction

  function automatic int unsigned stat_addr(input int unsigned nch);
    return 2 * nch;
  endfunction

  function automatic int unsigned mask_addr(input int unsigned nch);
    return 2 * nch + 1;
  endfunction

  function automatic int unsigned cfg_addr(input int unsigned nch);
    return 2 * nch + 2;
  endfunction

endpackage

// File: rtl/lim_regs.sv
module lim_regs
  import lim_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 4,
  localparam int FLAG_W = 2 * NUM_CH
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        lim_wdata,
  input  logic [FLAG_W-1:0]        mask_wdata,
  input  logic                     pol_wdata,
  output logic [NUM_CH*DATA_W-1:0] hi_flat,
  output logic [NUM_CH*DATA_W-1:0] lo_flat,
  output logic [FLAG_W-1:0]        mask_q,
  output irq_pol_e                 pol_q
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lim
    logic [DATA_W-1:0] hi_q, hi_d, lo_q, lo_d;
    logic              hi_en, lo_en;

    always_comb begin
      hi_en = we && (addr == ADDR_W'(hi_addr(c)));
      lo_en = we && (addr == ADDR_W'(lo_addr(c)));
      hi_d  = lim_wdata;
      lo_d  = lim_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= '1;
        lo_q <= '0;
      end else begin
        if (hi_en) hi_q <= hi_d;
        if (lo_en) lo_q <= lo_d;
      end
    end

    assign hi_flat[c*DATA_W +: DATA_W] = hi_q;
    assign lo_flat[c*DATA_W +: DATA_W] = lo_q;
  end

  logic        mask_en, pol_en;
  logic [FLAG_W-1:0] mask_d;
  irq_pol_e    pol_d;

  always_comb begin
    mask_en = we && (addr == ADDR_W'(mask_addr(NUM_CH)));
    pol_en  = we && (addr == ADDR_W'(cfg_addr(NUM_CH)));
    mask_d  = mask_wdata;
    pol_d   = pol_wdata ? POL_ACT_HIGH : POL_ACT_LOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pol_q  <= POL_ACT_LOW;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (pol_en)  pol_q  <= pol_d;
    end
  end

endmodule

// File: rtl/lim_compare.sv
module lim_compare #(
  parameter int DATA_W = 10,
  parameter int NUM_CH = 6,
  parameter int CH_W   = 3,
  localparam int FLAG_W = 2 * NUM_CH
) (
  input  logic                     valid,
  input  logic [CH_W-1:0]          ch,
  input  logic [DATA_W-1:0]        val,
  input  logic [NUM_CH*DATA_W-1:0] hi_flat,
  input  logic [NUM_CH*DATA_W-1:0] lo_flat,
  output logic [FLAG_W-1:0]        set_vec
);

  // One comparator pair per channel; only the addressed one may fire.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    logic sel;
    always_comb begin
      sel              = valid && (ch == CH_W'(c));
      set_vec[2*c]     = sel && (val > hi_flat[c*DATA_W +: DATA_W]);
      set_vec[2*c + 1] = sel && (val < lo_flat[c*DATA_W +: DATA_W]);
    end
  end

endmodule

// File: rtl/lim_status.sv
module lim_status #(
  parameter int FLAG_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_vec,
  input  logic              clr,
  output logic [FLAG_W-1:0] status_q
);

  logic [FLAG_W-1:0] status_d;
  logic              upd;

  // New violations win over a clear in the same cycle.
  always_comb begin
    upd      = clr || (|set_vec);
    status_d = (clr ? '0 : status_q) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status_q <= '0;
    else if (upd) status_q <= status_d;
  end

endmodule

// File: rtl/lim_irq_out.sv
module lim_irq_out
  import lim_pkg::*;
#(
  parameter int FLAG_W = 12
) (
  input  logic [FLAG_W-1:0] status,
  input  logic [FLAG_W-1:0] mask,
  input  irq_pol_e          pol,
  output logic              irq_oe,
  output logic              irq_o
);

  logic pending;

  always_comb begin
    pending = |(status & ~mask);
    irq_oe  = pending;
    irq_o   = (pol == POL_ACT_HIGH);
  end

endmodule

// File: rtl/lim_monitor.sv
module lim_monitor
  import lim_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int NUM_CH = 6,
  localparam int FLAG_W = 2 * NUM_CH,
  localparam int CH_W   = $clog2(NUM_CH + 1),
  localparam int ADDR_W = $clog2(2 * NUM_CH + 3),
  localparam int REG_W  = (DATA_W > FLAG_W) ? DATA_W : FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              result_valid,
  input  logic [CH_W-1:0]   result_ch,
  input  logic [DATA_W-1:0] result_val,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_oe,
  output logic              irq_o
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_CH*DATA_W-1:0] hi_flat, lo_flat;
  logic [FLAG_W-1:0]        mask_q, set_vec, status_q;
  irq_pol_e                 pol_q;
  logic                     stat_rd;

  lim_regs #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .we         (reg_we),
    .addr       (reg_addr),
    .lim_wdata  (reg_wdata[DATA_W-1:0]),
    .mask_wdata (reg_wdata[FLAG_W-1:0]),
    .pol_wdata  (reg_wdata[0]),
    .hi_flat    (hi_flat),
    .lo_flat    (lo_flat),
    .mask_q     (mask_q),
    .pol_q      (pol_q)
  );

  lim_compare #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_cmp (
    .valid   (result_valid),
    .ch      (result_ch),
    .val     (result_val),
    .hi_flat (hi_flat),
    .lo_flat (lo_flat),
    .set_vec (set_vec)
  );

  assign stat_rd = reg_re && (reg_addr == ADDR_W'(stat_addr(NUM_CH)));

  lim_status #(.FLAG_W(FLAG_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_vec  (set_vec),
    .clr      (stat_rd),
    .status_q (status_q)
  );

  lim_irq_out #(.FLAG_W(FLAG_W)) u_irq (
    .status (status_q),
    .mask   (mask_q),
    .pol    (pol_q),
    .irq_oe (irq_oe),
    .irq_o  (irq_o)
  );

  // Registered read path.
  logic [REG_W-1:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == ADDR_W'(hi_addr(c))) rdata_d = REG_W'(hi_flat[c*DATA_W +: DATA_W]);
      if (reg_addr == ADDR_W'(lo_addr(c))) rdata_d = REG_W'(lo_flat[c*DATA_W +: DATA_W]);
    end
    if (reg_addr == ADDR_W'(stat_addr(NUM_CH))) rdata_d = REG_W'(status_q);
    if (reg_addr == ADDR_W'(mask_addr(NUM_CH))) rdata_d = REG_W'(mask_q);
    if (reg_addr == ADDR_W'(cfg_addr(NUM_CH)))  rdata_d = REG_W'(pol_q == POL_ACT_HIGH);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rdata_d;
  end

endmodule

// File: rtl/lim_monitor_chk.sv
module lim_monitor_chk #(
  parameter int DATA_W = 10,
  parameter int NUM_CH = 6,
  localparam int FLAG_W = 2 * NUM_CH,
  localparam int CH_W   = $clog2(NUM_CH + 1),
  localparam int ADDR_W = $clog2(2 * NUM_CH + 3),
  localparam int REG_W  = (DATA_W > FLAG_W) ? DATA_W : FLAG_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              result_valid,
  input logic [CH_W-1:0]   result_ch,
  input logic              reg_we,
  input logic              reg_re,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              irq_oe,
  input logic              irq_o,
  input logic [FLAG_W-1:0] status_q
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(2 * NUM_CH);

  logic stat_rd;
  assign stat_rd = reg_re && (reg_addr == STAT_A);

  // R4: without a strobe no new flag appears
  p_no_flag_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |=> ((status_q & ~$past(status_q)) == '0));

  // R4: an out-of-range channel index leaves the status untouched
  p_bad_ch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && (int'(result_ch) >= NUM_CH) && !stat_rd) |=> (status_q == $past(status_q)));

  // R5: flags persist until a status read
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R6: a read with no concurrent strobe empties the status
  p_clear_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !result_valid) |=> (status_q == '0));

  // R6: the read returns the flags held at the read cycle
  p_read_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (reg_rdata == REG_W'($past(status_q))));

  // R8: the interrupt can only start after a result or a register write
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_oe) |-> $past(result_valid || reg_we));

  // R9: the driven level changes only through a register write
  p_level_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(irq_o));

endmodule

bind lim_monitor lim_monitor_chk #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .result_valid (result_valid),
  .result_ch    (result_ch),
  .reg_we       (reg_we),
  .reg_re       (reg_re),
  .reg_addr     (reg_addr),
  .reg_rdata    (reg_rdata),
  .irq_oe       (irq_oe),
  .irq_o        (irq_o),
  .status_q     (status_q)
);

// File: tb/test_lim_monitor.sv
module test_lim_monitor;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        result_valid;
  logic [2:0]  result_ch;
  logic [9:0]  result_val;
  logic        reg_we, reg_re;
  logic [3:0]  reg_addr;
  logic [11:0] reg_wdata;
  logic [11:0] reg_rdata;
  logic        irq_oe, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam int NCH  = 6;
  localparam int STAT = 2 * NCH;
  localparam int MSK  = 2 * NCH + 1;
  localparam int CFG  = 2 * NCH + 2;

  always #5 clk = ~clk;

  lim_monitor i_lim_monitor (
    .clk(clk), .rst_n(rst_n),
    .result_valid(result_valid), .result_ch(result_ch), .result_val(result_val),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_oe(irq_oe), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 12'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [11:0] d);
    reg_re = 1'b1; reg_addr = 4'(a);
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic strobe(input int c, input int v);
    result_valid = 1'b1; result_ch = 3'(c); result_val = 10'(v);
    @(negedge clk);
    result_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [11:0] d;
    int hi, lo, exp;
    rst_n = 1'b0; result_valid = 0; result_ch = 0; result_val = 0;
    reg_we = 0; reg_re = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values
    for (int c = 0; c < NCH; c++) begin
      rd(2*c, d);   chk("R1 upper limit", d, 12'h3FF);
      rd(2*c+1, d); chk("R1 lower limit", d, 0);
    end
    rd(STAT, d); chk("R1 status", d, 0);
    rd(MSK, d);  chk("R1 mask", d, 0);
    rd(CFG, d);  chk("R1 config", d, 0);
    chk("R1 irq_oe", irq_oe, 0);
    chk("R1 irq level", irq_o, 0);

    // R2 R3 R4 R8 R10: full code sweep per channel
    for (int c = 0; c < NCH; c++) begin
      hi = 700 + 20*c; lo = 100 + 30*c;
      wr(2*c, hi); wr(2*c+1, lo);
      rd(2*c, d);   chk("R10 upper readback", d, hi);
      rd(2*c+1, d); chk("R10 lower readback", d, lo);
      for (int v = 0; v < 1024; v++) begin
        strobe(c, v);
        exp = ((v > hi) ? (1 << (2*c)) : 0) | ((v < lo) ? (1 << (2*c+1)) : 0);
        chk("R8 irq_oe after result", irq_oe, (exp != 0));
        rd(STAT, d);
        chk("R2 R3 R4 status after result", d, exp);
      end
      chk("R8 irq_oe released after read", irq_oe, 0);
    end

    // R4: out-of-range index and idle cycles
    strobe(6, 1023); strobe(7, 0);
    chk("R4 bad index irq", irq_oe, 0);
    rd(STAT, d); chk("R4 bad index status", d, 0);
    result_ch = 0; result_val = 10'h3FF;
    @(negedge clk);
    rd(STAT, d); chk("R4 no strobe status", d, 0);

    // R5: sticky through in-range result
    strobe(0, 1023); strobe(0, 400);
    chk("R5 irq held", irq_oe, 1);
    rd(STAT, d); chk("R5 sticky status", d, 1);
    rd(STAT, d); chk("R6 cleared by read", d, 0);

    // R6: read and strobe in the same cycle
    strobe(1, 1023);
    reg_re = 1'b1; reg_addr = 4'(STAT);
    result_valid = 1'b1; result_ch = 3'd2; result_val = 10'd0;
    @(negedge clk);
    reg_re = 1'b0; result_valid = 1'b0;
    chk("R6 read data excludes same-cycle flag", reg_rdata, 1 << 2);
    rd(STAT, d); chk("R6 same-cycle flag kept", d, 1 << 5);

    // R7: masking
    wr(MSK, 1 << 6);
    rd(MSK, d); chk("R7 mask readback", d, 1 << 6);
    strobe(3, 1023);
    chk("R7 masked irq", irq_oe, 0);
    rd(STAT, d); chk("R7 masked flag recorded", d, 1 << 6);
    strobe(3, 0);
    chk("R7 unmasked irq", irq_oe, 1);
    rd(STAT, d); chk("R7 unmasked flag", d, 1 << 7);
    wr(MSK, 0);

    // R9: polarity
    wr(CFG, 1);
    rd(CFG, d); chk("R9 config readback", d, 1);
    strobe(4, 1023);
    chk("R9 irq_oe", irq_oe, 1);
    chk("R9 active high level", irq_o, 1);
    wr(CFG, 0);
    chk("R9 active low level", irq_o, 0);
    chk("R9 irq_oe kept", irq_oe, 1);
    rd(STAT, d); chk("R9 status", d, 1 << 8);
    chk("R8 irq_oe after clear", irq_oe, 0);

    // R10: a new limit applies to the next result
    wr(2*5, 1000);
    strobe(5, 900);
    rd(STAT, d); chk("R10 relaxed limit", d, 0);
    wr(2*5, 899);
    strobe(5, 900);
    rd(STAT, d); chk("R10 tightened limit", d, 1 << 10);

    done = 1;
    report();
  end

endmodule